// File: doc/BRIEF.md
# UART Register and Interrupt Front-End

This block is the software-facing half of a simple UART. A host reaches it through a single-cycle memory-mapped port that has four 32-bit word registers: control, receive data, transmit data and status. The block holds one FIFO for each direction. It drives the frame settings and the enable bits to a separate serial frame engine. It gives transmit characters to that engine through a valid/take pair and accepts received characters with an error flag. It raises one level-high interrupt.

Software fills the transmit FIFO by writing the transmit data register. It empties the receive FIFO by reading the receive data register. The status register shows the FIFO flags, the modem line states and a fill-level field, so a driver can poll that field until it reads zero after queuing output. Two pending bits and three error bits are sticky and are cleared by writing one to them. When the global enable is low, the block flushes both FIFOs and keeps the interrupt low.

Top module: `sio_reg_front`

## Requirements
- R1: After reset the control register reads 0. The status register reads 0x420, with receive-empty at bit 5 and transmit-empty at bit 10 set and the pending bits clear, when cts_i and rts_i are low. irq_o is low.
- R2: Control is at byte offset 0x0. Its writable fields are: data length [1:0], two stop bits [2], parity mode [6:4], auto flow [12], level select [14], global enable [15], receive DMA enable [16], transmit DMA enable [17], receive interrupt enable [18], transmit interrupt enable [19] and loopback [20]. All other bits read 0. Each field drives its cfg_*/dma output.
- R3: A write to offset 0x8 while enabled pushes wdata_i[7:0] into the transmit FIFO. tx_valid_o and tx_data_o present the characters in write order, and tx_take_i pops one. Status bit 6 shows full. A write while full is dropped and sets status bit 3.
- R4: A read of offset 0x4 returns the oldest received character in bits [7:0] and pops it. A read of the empty FIFO returns 0. Status bit 5 shows receive empty.
- R5: A received character that arrives while the receive FIFO is full is dropped and sets status bit 2.
- R6: A received character with rx_err_i high sets status bit 4.
- R7: Status bits [16:11] hold the fill level of the transmit FIFO when control bit 14 is 1, and of the receive FIFO when it is 0.
- R8: Receive pending (status bit 0) is set in each cycle that the receive FIFO is non-empty. Transmit pending (bit 1) is set in each cycle that the transmit FIFO is not full. Both bits stay set until cleared. Writing one to status bits 0 to 4 clears those bits. Writing zero leaves them unchanged.
- R9: irq_o is high when enabled and either receive pending with bit 18 set or transmit pending with bit 19 set.
- R10: With the global enable low, both FIFOs are emptied, received characters and transmit writes are dropped without setting error bits, the pending bits read 0 and irq_o is low.
- R11: Status bit 7 mirrors cts_i and status bit 8 mirrors rts_i.
- R12: Status bit 10 is set exactly when the transmit FIFO holds no characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Level-high interrupt |
| cfg_len_o | output | 2 | Data length code |
| cfg_stop2_o | output | 1 | Two stop bits |
| cfg_parity_o | output | 3 | Parity mode |
| cfg_flow_o | output | 1 | Auto flow control enable |
| cfg_loop_o | output | 1 | Internal loopback |
| cfg_en_o | output | 1 | Global enable |
| rx_dma_en_o | output | 1 | Receive DMA enable |
| tx_dma_en_o | output | 1 | Transmit DMA enable |
| tx_valid_o | output | 1 | Transmit character available |
| tx_data_o | output | 8 | Oldest transmit character |
| tx_take_i | input | 1 | Frame engine takes the character |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_err_i | input | 1 | Parity, frame or break error with the character |
| cts_i | input | 1 | CTS line state |
| rts_i | input | 1 | RTS line state |

## Verification
The assertions check on every cycle the following: a disabled block keeps irq_o low and empties both FIFOs, a non-empty receive FIFO sets receive pending, a write-one with an empty receive FIFO clears it, and a full FIFO drops a push and flags the error. Only the bench scenarios can show the rest: character order through both FIFOs, the exact control readback mask, fill-level selection, and the sticky life of the pending bits across reads, clears and partial drains.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned LVL_W  = 6;

  // word index = addr[3:2]
  localparam logic [1:0] IDX_CTL  = 2'd0;
  localparam logic [1:0] IDX_RXD  = 2'd1;
  localparam logic [1:0] IDX_TXD  = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  localparam int unsigned B_LSEL = 14;
  localparam int unsigned B_EN   = 15;
  localparam int unsigned B_RXDE = 16;
  localparam int unsigned B_TXDE = 17;
  localparam int unsigned B_RXIE = 18;
  localparam int unsigned B_TXIE = 19;
  localparam int unsigned B_LOOP = 20;

  localparam logic [31:0] CTL_MASK = 32'h001F_D077;

  // sticky flag order inside status [4:0]
  localparam int unsigned NFLAG = 5;
  localparam logic [NFLAG-1:0] FLAG_HOLD = 5'b00011;

  typedef struct packed {
    logic [14:0]      rsvd_hi;
    logic [LVL_W-1:0] level;
    logic             tx_empty;
    logic             rsvd9;
    logic             rts;
    logic             cts;
    logic             tx_full;
    logic             rx_empty;
    logic             rx_st_err;
    logic             tx_err;
    logic             rx_ovr;
    logic             tx_pend;
    logic             rx_pend;
  } stat_t;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic                           push_i,
  input  logic [W-1:0]                   data_i,
  input  logic                           pop_i,
  output logic [W-1:0]                   data_o,
  output logic [$clog2(DEPTH+1)-1:0]     count_o,
  output logic                           empty_o,
  output logic                           full_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sio_flags.sv
module sio_flags #(
  parameter int unsigned        NB   = 5,
  parameter logic [NB-1:0]      HOLD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  output logic [NB-1:0] q_o
);
  for (genvar b = 0; b < NB; b++) begin : g_bit
    logic q;
    if (HOLD[b]) begin : g_held
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    q <= 1'b0;
        else if (!en_i) q <= 1'b0;
        else            q <= (q && !clr_i[b]) || set_i[b];
      end
    end else begin : g_free
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= (q && !clr_i[b]) || set_i[b];
      end
    end
    assign q_o[b] = q;
  end
endmodule

// File: rtl/sio_reg_front.sv
module sio_reg_front
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic [1:0]        cfg_len_o,
  output logic              cfg_stop2_o,
  output logic [2:0]        cfg_parity_o,
  output logic              cfg_flow_o,
  output logic              cfg_loop_o,
  output logic              cfg_en_o,
  output logic              rx_dma_en_o,
  output logic              tx_dma_en_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_take_i,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_err_i,
  input  logic              cts_i,
  input  logic              rts_i
);
  localparam int unsigned TCW = $clog2(TX_DEPTH+1);
  localparam int unsigned RCW = $clog2(RX_DEPTH+1);

  logic [31:0]      ctl_q;
  logic             hit, en;
  logic [1:0]       idx;
  logic             wr_ctl, wr_tx, wr_stat, rd_rx;
  logic [TCW-1:0]   tx_cnt;
  logic [RCW-1:0]   rx_cnt;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [7:0]       rx_head;
  logic             rx_push, ovr_set, txerr_set, rxst_set;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  stat_t            stat;

  // access decode: word aligned, upper bits zero
  assign hit     = req_i && ((addr_i >> 4) == '0) && (addr_i[1:0] == 2'b00);
  assign idx     = addr_i[3:2];
  assign wr_ctl  = hit && we_i  && (idx == IDX_CTL);
  assign wr_tx   = hit && we_i  && (idx == IDX_TXD) && en;
  assign wr_stat = hit && we_i  && (idx == IDX_STAT);
  assign rd_rx   = hit && !we_i && (idx == IDX_RXD) && en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (wr_ctl) ctl_q <= wdata_i & CTL_MASK;
  end

  assign en           = ctl_q[B_EN];
  assign cfg_len_o    = ctl_q[1:0];
  assign cfg_stop2_o  = ctl_q[2];
  assign cfg_parity_o = ctl_q[6:4];
  assign cfg_flow_o   = ctl_q[12];
  assign cfg_en_o     = en;
  assign cfg_loop_o   = ctl_q[B_LOOP];
  assign rx_dma_en_o  = ctl_q[B_RXDE];
  assign tx_dma_en_o  = ctl_q[B_TXDE];

  sio_fifo #(.W(CHAR_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!en),
    .push_i  (wr_tx),
    .data_i  (wdata_i[CHAR_W-1:0]),
    .pop_i   (tx_take_i),
    .data_o  (tx_data_o),
    .count_o (tx_cnt),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  assign rx_push = rx_valid_i && en;

  sio_fifo #(.W(CHAR_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!en),
    .push_i  (rx_push),
    .data_i  (rx_data_i),
    .pop_i   (rd_rx),
    .data_o  (rx_head),
    .count_o (rx_cnt),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  assign tx_valid_o = !tx_empty;

  assign ovr_set   = rx_push && rx_full;
  assign txerr_set = wr_tx && tx_full;
  assign rxst_set  = rx_push && rx_err_i;

  assign flag_set = {rxst_set, txerr_set, ovr_set, !tx_full, !rx_empty};
  assign flag_clr = wr_stat ? wdata_i[NFLAG-1:0] : '0;

  sio_flags #(.NB(NFLAG), .HOLD(FLAG_HOLD)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .q_o    (flag_q)
  );

  always_comb begin
    stat           = '0;
    stat.rx_pend   = flag_q[0];
    stat.tx_pend   = flag_q[1];
    stat.rx_ovr    = flag_q[2];
    stat.tx_err    = flag_q[3];
    stat.rx_st_err = flag_q[4];
    stat.rx_empty  = rx_empty;
    stat.tx_full   = tx_full;
    stat.cts       = cts_i;
    stat.rts       = rts_i;
    stat.tx_empty  = tx_empty;
    stat.level     = ctl_q[B_LSEL] ? LVL_W'(tx_cnt) : LVL_W'(rx_cnt);
  end

  always_comb begin
    rdata_o = '0;
    if (hit && !we_i) begin
      case (idx)
        IDX_CTL:  rdata_o = ctl_q;
        IDX_RXD:  rdata_o = rx_empty ? '0 : {24'd0, rx_head};
        IDX_STAT: rdata_o = stat;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = en && ((flag_q[0] && ctl_q[B_RXIE]) || (flag_q[1] && ctl_q[B_TXIE]));
endmodule

// File: rtl/sio_reg_front_chk.sv
module sio_reg_front_chk #(
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           en,
  input logic                           irq_o,
  input logic [$clog2(TX_DEPTH+1)-1:0]  tx_cnt,
  input logic [$clog2(RX_DEPTH+1)-1:0]  rx_cnt,
  input logic                           wr_tx,
  input logic                           tx_take_i,
  input logic                           rx_push,
  input logic                           rd_rx,
  input logic                           wr_stat,
  input logic [4:0]                     flag_q,
  input logic [31:0]                    wdata_i
);
  assert_quiet_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !irq_o);

  assert_flush_when_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (tx_cnt == '0) && (rx_cnt == '0));

  assert_tx_full_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tx && tx_cnt == TX_DEPTH && !tx_take_i) |=> ($stable(tx_cnt) && flag_q[3]));

  assert_rx_overrun_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_cnt == RX_DEPTH && !rd_rx) |=> ($stable(rx_cnt) && flag_q[2]));

  assert_rx_pend_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && rx_cnt != '0) |=> flag_q[0]);

  assert_rx_pend_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[0] && rx_cnt == '0 && !rx_push) |=> !flag_q[0]);

  assert_level_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt <= TX_DEPTH) && (rx_cnt <= RX_DEPTH));
endmodule

bind sio_reg_front sio_reg_front_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en        (en),
  .irq_o     (irq_o),
  .tx_cnt    (tx_cnt),
  .rx_cnt    (rx_cnt),
  .wr_tx     (wr_tx),
  .tx_take_i (tx_take_i),
  .rx_push   (rx_push),
  .rd_rx     (rd_rx),
  .wr_stat   (wr_stat),
  .flag_q    (flag_q),
  .wdata_i   (wdata_i)
);

// File: tb/test_sio_reg_front.sv
`timescale 1ns/1ps
module test_sio_reg_front;
  localparam int TXD = 16;
  localparam int RXD = 16;
  localparam logic [3:0] A_CTL = 4'h0, A_RXD = 4'h4, A_TXD = 4'h8, A_STAT = 4'hC;
  localparam logic [31:0] EN = 32'h8000, LSEL = 32'h4000, RXIE = 32'h4_0000, TXIE = 32'h8_0000;

  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, tx_valid, tx_take = 0, rx_valid = 0, rx_err = 0, cts = 0, rts = 0;
  logic [7:0] tx_data, rx_data = 0;
  logic [1:0] len; logic stop2, flow, lpbk, en_o, rxde, txde; logic [2:0] par;
  int checks = 0, errors = 0;
  logic [31:0] r;

  always #10 clk = ~clk;

  sio_reg_front #(.ADDR_W(4), .TX_DEPTH(TXD), .RX_DEPTH(RXD)) i_sio_reg_front (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .cfg_len_o(len), .cfg_stop2_o(stop2), .cfg_parity_o(par),
    .cfg_flow_o(flow), .cfg_loop_o(lpbk), .cfg_en_o(en_o), .rx_dma_en_o(rxde),
    .tx_dma_en_o(txde), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_take_i(tx_take),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_err_i(rx_err), .cts_i(cts), .rts_i(rts));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(); @(negedge clk); endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic rx_in(input logic [7:0] c, input logic e);
    @(negedge clk); rx_valid = 1; rx_data = c; rx_err = e;
    @(negedge clk); rx_valid = 0; rx_err = 0;
  endtask

  task automatic take();
    @(negedge clk); tx_take = 1;
    @(negedge clk); tx_take = 0;
  endtask

  task automatic t_reset();
    rd(A_CTL, r);  chk("R1 ctl", r, 0);
    rd(A_STAT, r); chk("R1 stat", r, 32'h420);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_ctl();
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, r); chk("R2 ctl mask", r, 32'h001F_D077);
    chk("R2 cfg outs", {20'd0, len, stop2, par, flow, lpbk, en_o, rxde, txde},
        {20'd0, 2'b11, 1'b1, 3'b111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1});
    wr(A_CTL, 32'h0000_0051);
    chk("R2 cfg partial", {24'd0, len, stop2, par, en_o}, {24'd0, 2'b01, 1'b0, 3'b101, 1'b0});
    wr(A_CTL, 0);
  endtask

  task automatic t_tx();
    wr(A_CTL, EN | LSEL);
    for (int i = 0; i < TXD; i++) wr(A_TXD, 32'hFFFF_FF00 | (8'h30 + i));
    rd(A_STAT, r);
    chk("R3 full bit6", {31'd0, r[6]}, 1);
    chk("R7 tx level", {26'd0, r[16:11]}, TXD);
    chk("R12 not empty", {31'd0, r[10]}, 0);
    wr(A_TXD, 32'hEE);
    rd(A_STAT, r);
    chk("R3 drop err bit3", {31'd0, r[3]}, 1);
    chk("R3 level after drop", {26'd0, r[16:11]}, TXD);
    for (int i = 0; i < TXD; i++) begin
      idle();
      chk("R3 order", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'(8'h30 + i)});
      take();
    end
    idle();
    chk("R3 drained", {31'd0, tx_valid}, 0);
    rd(A_STAT, r);
    chk("R12 empty bit10", {31'd0, r[10]}, 1);
    chk("R7 level zero", {26'd0, r[16:11]}, 0);
    wr(A_STAT, 32'h8);
    rd(A_STAT, r); chk("R8 txerr cleared", {31'd0, r[3]}, 0);
  endtask

  task automatic t_rx();
    wr(A_CTL, EN);
    rx_in(8'h41, 0); rx_in(8'h42, 1); rx_in(8'h43, 0);
    rd(A_STAT, r);
    chk("R4 not empty", {31'd0, r[5]}, 0);
    chk("R7 rx level", {26'd0, r[16:11]}, 3);
    chk("R6 st err", {31'd0, r[4]}, 1);
    rd(A_RXD, r); chk("R4 char0", r, 32'h41);
    rd(A_RXD, r); chk("R4 char1", r, 32'h42);
    rd(A_RXD, r); chk("R4 char2", r, 32'h43);
    rd(A_RXD, r); chk("R4 empty read", r, 0);
    rd(A_STAT, r);
    chk("R4 empty bit5", {31'd0, r[5]}, 1);
    chk("R4 level zero", {26'd0, r[16:11]}, 0);
    wr(A_STAT, 0);
    rd(A_STAT, r); chk("R8 zero write keeps", {31'd0, r[4]}, 1);
    wr(A_STAT, 32'h10);
    rd(A_STAT, r); chk("R8 st err cleared", {31'd0, r[4]}, 0);
  endtask

  task automatic t_ovr();
    for (int i = 0; i <= RXD; i++) rx_in(8'(8'h60 + i), 0);
    rd(A_STAT, r);
    chk("R5 ovr bit2", {31'd0, r[2]}, 1);
    chk("R5 level", {26'd0, r[16:11]}, RXD);
    rd(A_RXD, r); chk("R5 first", r, 32'h60);
    for (int i = 1; i < RXD; i++) rd(A_RXD, r);
    chk("R5 last kept", r, 32'(8'h60 + RXD - 1));
    rd(A_RXD, r); chk("R5 extra dropped", r, 0);
    wr(A_STAT, 32'h4);
    rd(A_STAT, r); chk("R8 ovr cleared", {31'd0, r[2]}, 0);
  endtask

  task automatic t_pend();
    wr(A_STAT, 32'h1F);
    wr(A_CTL, EN | RXIE);
    idle();
    chk("R9 no irq idle", {31'd0, irq}, 0);
    rx_in(8'h55, 0);
    idle();
    chk("R9 rx irq", {31'd0, irq}, 1);
    rd(A_RXD, r);
    idle();
    chk("R8 rx pend sticky", {31'd0, irq}, 1);
    wr(A_STAT, 32'h1);
    chk("R8 rx pend w1c", {31'd0, irq}, 0);
    rd(A_STAT, r); chk("R8 bit0 clear", {31'd0, r[0]}, 0);
    wr(A_CTL, EN | TXIE);
    chk("R9 tx irq", {31'd0, irq}, 1);
    wr(A_STAT, 32'h2);
    chk("R8 tx pend reasserts", {31'd0, irq}, 1);
    for (int i = 0; i < TXD; i++) wr(A_TXD, i);
    wr(A_STAT, 32'h2);
    chk("R8 tx pend clear full", {31'd0, irq}, 0);
    take();
    idle();
    chk("R8 tx pend on space", {31'd0, irq}, 1);
  endtask

  task automatic t_lines();
    cts = 1; rts = 0;
    rd(A_STAT, r); chk("R11 cts", {30'd0, r[8:7]}, 2'b01);
    cts = 0; rts = 1;
    rd(A_STAT, r); chk("R11 rts", {30'd0, r[8:7]}, 2'b10);
    rts = 0;
  endtask

  task automatic t_off();
    wr(A_CTL, EN | RXIE | TXIE | LSEL);
    rx_in(8'h77, 0);
    wr(A_CTL, RXIE | TXIE | LSEL);
    chk("R10 irq low", {31'd0, irq}, 0);
    idle();
    chk("R10 tx flushed", {31'd0, tx_valid}, 0);
    rx_in(8'h12, 0);
    wr(A_TXD, 32'h34);
    rd(A_STAT, r);
    chk("R10 tx level", {26'd0, r[16:11]}, 0);
    chk("R10 flags", {27'd0, r[4:0]}, 0);
    chk("R10 empties", {30'd0, r[10], r[5]}, 2'b11);
    wr(A_CTL, 0);
    rd(A_STAT, r); chk("R10 rx level", {26'd0, r[16:11]}, 0);
    chk("R10 tx still", {31'd0, tx_valid}, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_ctl();
    t_tx();
    t_rx();
    t_ovr();
    t_pend();
    t_lines();
    t_off();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule